// File: doc/BRIEF.md
# Single-Channel PWM Generator with Selectable Register Layout

This block produces one pulse-width-modulated output from four 32-bit registers reached over a simple memory-mapped bus: a period length, a duty length, a live counter and a control word. A build-time parameter picks one of three layouts. The layout fixes where each register sits in the four-word window, which control bits start the generator and set the output levels, and whether the counter advances on every clock or on every second clock.

Software writes the period and duty counts while the generator is stopped. It writes zero to the counter to start from a known phase, then sets the enable bits. While running, the counter counts from zero to period minus one and wraps. The output shows the active level while the count is below the duty value and the inactive level otherwise. Stopping freezes the counter and drives the inactive level.

Top module: `pwm_var_top`

## Requirements
- R1: After reset all four registers read zero and `pwm_out` is low.
- R2: Word slots by byte offset are: layout A has counter 0x0, duty 0x4, period 0x8 and control 0xC; layout B has counter 0x0, period 0x4, duty 0x8 and control 0xC; layout C has control 0x0, period 0x4, duty 0x8 and counter 0xC. Period, duty and the full control word read back exactly as written.
- R3: In layout A the generator runs only when control bits 0 and 3 are both set. The active level is high and the inactive level is low.
- R4: In layouts B and C, control bit 0 runs the generator. Bit 3 sets the active level (1 high, 0 low) and bit 4 sets the inactive level (1 high, 0 low). Every other control bit is stored and has no effect.
- R5: The counter advances once every 2 clocks in layout A and once every clock in layouts B and C. It returns to zero on the tick after it reaches period minus one. A period of 0 or 1 keeps it at zero.
- R6: While running, `pwm_out` shows the active level for clocks whose count is below duty and the inactive level otherwise. The output is registered, so it lags the count by one clock.
- R7: A duty of period or more holds the output active for the whole period. A duty of zero holds it inactive.
- R8: While stopped, the counter holds its value and `pwm_out` shows the inactive level.
- R9: A bus write of zero to the counter slot sets the counter to zero on that clock edge and also clears the layout A tick phase. A nonzero write to the counter slot is ignored.
- R10: A read of the counter slot returns the live count in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Selects this block for the current bus cycle |
| bus_wr | input | 1 | Write strobe, taken at the clock edge while `bus_sel` is high |
| bus_addr | input | ADDR_W | Byte address; bits [3:2] pick the slot and bits [1:0] must be zero |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for `bus_addr` |
| pwm_out | output | 1 | Registered PWM output |

## Verification
The properties assume that every bus input is known from the first clock after reset. The full-period property (duty at least period) only claims anything while the count is already below the period, because a period shrunk while running can leave one count above it for a single tick. The stimulus reprograms period and duty only while the generator is stopped, and it restarts the counter before enabling. The single exception is the restart test, which writes the counter while running, and that is the case the restart property covers.

// File: rtl/pwm_var_pkg.sv
// Package: shared layout selector, register identifiers and the
// per-layout slot and prescale rules used by every module of the block.
package pwm_var_pkg;

    typedef enum logic [1:0] {
        MAP_A = 2'd0,
        MAP_B = 2'd1,
        MAP_C = 2'd2
    } map_e;

    typedef enum logic [1:0] {
        REG_CNT  = 2'd0,
        REG_DUTY = 2'd1,
        REG_PER  = 2'd2,
        REG_CTRL = 2'd3
    } reg_e;

    // Word slot (byte address bits [3:2]) of a register in a layout.
    function automatic logic [1:0] slot_of(map_e m, reg_e r);
        logic [1:0] s;
        case (m)
            MAP_A: begin
                case (r)
                    REG_CNT:  s = 2'd0;
                    REG_DUTY: s = 2'd1;
                    REG_PER:  s = 2'd2;
                    default:  s = 2'd3;
                endcase
            end
            MAP_B: begin
                case (r)
                    REG_CNT:  s = 2'd0;
                    REG_PER:  s = 2'd1;
                    REG_DUTY: s = 2'd2;
                    default:  s = 2'd3;
                endcase
            end
            default: begin
                case (r)
                    REG_CTRL: s = 2'd0;
                    REG_PER:  s = 2'd1;
                    REG_DUTY: s = 2'd2;
                    default:  s = 2'd3;
                endcase
            end
        endcase
        return s;
    endfunction

    // Input clocks per counter tick in a layout.
    function automatic int prescale_of(map_e m);
        return (m == MAP_A) ? 2 : 1;
    endfunction

endpackage

// File: rtl/pwm_var_regs.sv
// Register file and bus decode.
// Holds period, duty and control. It turns a zero write to the counter
// slot into a one-cycle clear pulse and multiplexes read data.
// Assumes word-aligned accesses: an unaligned address neither writes
// nor reads anything.
module pwm_var_regs
    import pwm_var_pkg::*;
#(
    parameter map_e LAYOUT = MAP_B,
    parameter int   DATA_W = 32,
    parameter int   ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] live_cnt,
    output logic [DATA_W-1:0] period_q,
    output logic [DATA_W-1:0] duty_q,
    output logic [DATA_W-1:0] ctrl_q,
    output logic              cnt_clear
);
    localparam logic [1:0] S_CNT  = slot_of(LAYOUT, REG_CNT);
    localparam logic [1:0] S_DUTY = slot_of(LAYOUT, REG_DUTY);
    localparam logic [1:0] S_PER  = slot_of(LAYOUT, REG_PER);
    localparam logic [1:0] S_CTRL = slot_of(LAYOUT, REG_CTRL);
    localparam int         SLOT_LSB = 2;

    logic [1:0] slot;
    logic       aligned;
    logic       wr_hit;

    // Address split into slot and alignment.
    always_comb begin
        slot    = bus_addr[SLOT_LSB +: 2];
        aligned = (bus_addr[SLOT_LSB-1:0] == '0);
        wr_hit  = bus_sel && bus_wr && aligned;
    end

    // Counter restart request: a zero written to the counter slot.
    always_comb begin
        cnt_clear = wr_hit && (slot == S_CNT) && (bus_wdata == '0);
    end

    // Storage of the three programmable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= '0;
            duty_q   <= '0;
            ctrl_q   <= '0;
        end else if (wr_hit) begin
            if (slot == S_PER)  period_q <= bus_wdata;
            if (slot == S_DUTY) duty_q   <= bus_wdata;
            if (slot == S_CTRL) ctrl_q   <= bus_wdata;
        end
    end

    // Read data multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            if (slot == S_CNT)  bus_rdata = live_cnt;
            if (slot == S_DUTY) bus_rdata = duty_q;
            if (slot == S_PER)  bus_rdata = period_q;
            if (slot == S_CTRL) bus_rdata = ctrl_q;
        end
    end

endmodule

// File: rtl/pwm_var_ctldec.sv
// Control word decode.
// Derives the run condition and the active and inactive output levels
// from the control bits that the selected layout gives meaning to.
// Assumes the other control bits are reserved.
module pwm_var_ctldec
    import pwm_var_pkg::*;
#(
    parameter map_e LAYOUT = MAP_B
) (
    input  logic b_en,
    input  logic b_lvl_act,
    input  logic b_lvl_idle,
    output logic run,
    output logic act_lvl,
    output logic inact_lvl
);
    localparam bit IS_A = (LAYOUT == MAP_A);

    // Layout A needs a second enable bit and has fixed levels.
    always_comb begin
        run       = b_en && (IS_A ? b_lvl_act : 1'b1);
        act_lvl   = IS_A ? 1'b1 : b_lvl_act;
        inact_lvl = IS_A ? 1'b0 : b_lvl_idle;
    end

endmodule

// File: rtl/pwm_var_timebase.sv
// Tick prescaler and period counter.
// With DIV above 1 a phase counter makes one tick every DIV clocks
// while running. The phase restarts when the generator stops or on a
// counter clear. The period counter wraps after period-1 and a clear
// takes priority over a tick.
module pwm_var_timebase #(
    parameter int DATA_W = 32,
    parameter int DIV    = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              clear,
    input  logic [DATA_W-1:0] period,
    output logic [DATA_W-1:0] cnt_q
);
    logic            tick;
    logic [DATA_W:0] nxt;
    logic            wrap;

    generate
        if (DIV <= 1) begin : g_nodiv
            // Every running clock is a tick.
            always_comb tick = run;
        end else begin : g_div
            localparam int PW = $clog2(DIV);
            localparam logic [PW-1:0] LAST = PW'(DIV - 1);
            logic [PW-1:0] ph_q;

            // Phase counter inside one prescaled tick.
            always_ff @(posedge clk) begin
                if (!rst_n || !run || clear) ph_q <= '0;
                else if (ph_q == LAST)        ph_q <= '0;
                else                          ph_q <= ph_q + 1'b1;
            end

            // Tick on the last phase of each group.
            always_comb tick = run && (ph_q == LAST);
        end
    endgenerate

    // Wrap test made one bit wider so period 0 never underflows.
    always_comb begin
        nxt  = {1'b0, cnt_q} + 1'b1;
        wrap = (nxt >= {1'b0, period});
    end

    // Period counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt_q <= '0;
        else if (tick)       cnt_q <= wrap ? '0 : nxt[DATA_W-1:0];
    end

endmodule

// File: rtl/pwm_var_outstage.sv
// Output stage: compares the count against duty and registers the level.
// Assumes the levels come from the control decode.
// The registered pin lags the count by one clock.
module pwm_var_outstage #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [DATA_W-1:0] cnt,
    input  logic [DATA_W-1:0] duty,
    input  logic              act_lvl,
    input  logic              inact_lvl,
    output logic              pwm_q
);
    logic in_pulse;

    // Active phase of the period.
    always_comb in_pulse = run && (cnt < duty);

    // Registered output level.
    always_ff @(posedge clk) begin
        if (!rst_n) pwm_q <= 1'b0;
        else        pwm_q <= in_pulse ? act_lvl : inact_lvl;
    end

endmodule

// File: rtl/pwm_var_top.sv
// Top of the single-channel PWM generator.
// Wires the register file, control decode, timebase and output stage.
// LAYOUT selects the slot map, the meaning of the enable bits and the
// prescale. Assumes a single clock domain and synchronous reset.
module pwm_var_top
    import pwm_var_pkg::*;
#(
    parameter map_e LAYOUT = MAP_B,
    parameter int   DATA_W = 32,
    parameter int   ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              pwm_out
);
    localparam int DIV = prescale_of(LAYOUT);

    logic [DATA_W-1:0] period_q;
    logic [DATA_W-1:0] duty_q;
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] cnt_q;
    logic              cnt_clear;
    logic              run;
    logic              act_lvl;
    logic              inact_lvl;

    pwm_var_regs #(.LAYOUT(LAYOUT), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .live_cnt  (cnt_q),
        .period_q  (period_q),
        .duty_q    (duty_q),
        .ctrl_q    (ctrl_q),
        .cnt_clear (cnt_clear)
    );

    pwm_var_ctldec #(.LAYOUT(LAYOUT)) u_dec (
        .b_en       (ctrl_q[0]),
        .b_lvl_act  (ctrl_q[3]),
        .b_lvl_idle (ctrl_q[4]),
        .run        (run),
        .act_lvl    (act_lvl),
        .inact_lvl  (inact_lvl)
    );

    pwm_var_timebase #(.DATA_W(DATA_W), .DIV(DIV)) u_tb (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .clear  (cnt_clear),
        .period (period_q),
        .cnt_q  (cnt_q)
    );

    pwm_var_outstage #(.DATA_W(DATA_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .cnt       (cnt_q),
        .duty      (duty_q),
        .act_lvl   (act_lvl),
        .inact_lvl (inact_lvl),
        .pwm_q     (pwm_out)
    );

endmodule

// File: rtl/pwm_var_chk.sv
// Checker for pwm_var_top: temporal properties over the run state,
// the counter and the output pin. It is bound to every instance.
module pwm_var_chk
    import pwm_var_pkg::*;
#(
    parameter map_e LAYOUT = MAP_B,
    parameter int   DW     = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run,
    input logic          clear,
    input logic [DW-1:0] cnt,
    input logic [DW-1:0] duty,
    input logic [DW-1:0] period,
    input logic          act,
    input logic          inact,
    input logic          pwm,
    input logic          ctrl_b3
);
    // R8
    hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clear) |=> $stable(cnt));

    // R8
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (pwm == $past(inact)));

    // R9
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt == '0));

    // R7
    zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && duty == '0) |=> (pwm == $past(inact)));

    // R7
    full_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && period != '0 && duty >= period && cnt < period) |=> (pwm == $past(act)));

    // R5
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (LAYOUT != MAP_A && run && !clear && period != '0 && cnt == period - 1'b1)
        |=> (cnt == '0));

    // R3
    dual_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (LAYOUT == MAP_A && run) |-> ctrl_b3);

endmodule

bind pwm_var_top pwm_var_chk #(.LAYOUT(LAYOUT), .DW(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .clear   (cnt_clear),
    .cnt     (cnt_q),
    .duty    (duty_q),
    .period  (period_q),
    .act     (act_lvl),
    .inact   (inact_lvl),
    .pwm     (pwm_out),
    .ctrl_b3 (ctrl_q[3])
);

// File: tb/sim_pwm_var_top.sv
module sim_pwm_var_top;
    import pwm_var_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  sel = '0;
    logic        wr = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata [3];
    logic [2:0]  pout;
    int          n_chk = 0;
    int          n_bad = 0;

    always #10 clk = ~clk;

    pwm_var_top #(.LAYOUT(MAP_A)) u0 (.clk(clk), .rst_n(rst_n), .bus_sel(sel[0]), .bus_wr(wr),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata[0]), .pwm_out(pout[0]));
    pwm_var_top #(.LAYOUT(MAP_B)) u1 (.clk(clk), .rst_n(rst_n), .bus_sel(sel[1]), .bus_wr(wr),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata[1]), .pwm_out(pout[1]));
    pwm_var_top #(.LAYOUT(MAP_C)) u2 (.clk(clk), .rst_n(rst_n), .bus_sel(sel[2]), .bus_wr(wr),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata[2]), .pwm_out(pout[2]));

    // register ids: 0 counter, 1 duty, 2 period, 3 control
    function automatic logic [3:0] off(int inst, int r);
        case (inst)
            0: return (r == 0) ? 4'h0 : (r == 1) ? 4'h4 : (r == 2) ? 4'h8 : 4'hC;
            1: return (r == 0) ? 4'h0 : (r == 1) ? 4'h8 : (r == 2) ? 4'h4 : 4'hC;
            default: return (r == 0) ? 4'hC : (r == 1) ? 4'h8 : (r == 2) ? 4'h4 : 4'h0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input int inst, input int r, input logic [31:0] v);
        @(negedge clk);
        sel = 3'b001 << inst; wr = 1'b1; addr = off(inst, r); wdata = v;
        @(negedge clk);
        sel = '0; wr = 1'b0; wdata = '0;
    endtask

    task automatic rd_reg(input int inst, input int r, output logic [31:0] v);
        @(negedge clk);
        addr = off(inst, r);
        #1 v = rdata[inst];
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // count clocks at the active level over n clocks
    task automatic meas(input int inst, input logic act, input int n, output int hits);
        hits = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (pout[inst] == act) hits++;
        end
    endtask

    // {period[7:0], duty[7:0], active-high}
    localparam logic [16:0] VEC [6] = '{
        {8'd5, 8'd2, 1'b1},
        {8'd8, 8'd8, 1'b0},
        {8'd6, 8'd0, 1'b1},
        {8'd4, 8'd9, 1'b0},
        {8'd7, 8'd3, 1'b0},
        {8'd3, 8'd1, 1'b1}
    };

    initial begin
        #(20 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v, c1, c2;
        int hits;
        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        for (int i = 0; i < 3; i++) begin
            chk(pout[i] == 1'b0, "R1 pin low after reset", 32'(pout[i]), 0);
            for (int r = 0; r < 4; r++) begin
                rd_reg(i, r, v);
                chk(v == 0, "R1 register zero after reset", v, 0);
            end
        end

        // R2: read back through each layout's slots, reserved control bits kept
        for (int i = 0; i < 3; i++) begin
            wr_reg(i, 2, 32'h11 + i);
            wr_reg(i, 1, 32'h22 + i);
            wr_reg(i, 3, 32'hA5A5_0120);
            rd_reg(i, 2, v); chk(v == 32'h11 + i, "R2 period slot", v, 32'h11 + i);
            rd_reg(i, 1, v); chk(v == 32'h22 + i, "R2 duty slot", v, 32'h22 + i);
            rd_reg(i, 3, v); chk(v == 32'hA5A5_0120, "R2 control slot", v, 32'hA5A5_0120);
            rd_reg(i, 0, v); chk(v == 0, "R10 counter idle read", v, 0);
        end

        // R5 R6 R7: vector table over all three layouts
        foreach (VEC[n]) begin
            for (int i = 0; i < 3; i++) begin
                logic [7:0]  p = VEC[n][16:9];
                logic [7:0]  d = VEC[n][8:1];
                logic        pol = VEC[n][0];
                logic        act = (i == 0) ? 1'b1 : pol;
                logic [31:0] ctl = (i == 0) ? 32'h9 : (32'h3 | (32'(pol) << 3) | (32'(!pol) << 4));
                int          exp = 4 * ((d < p) ? int'(d) : int'(p));
                wr_reg(i, 3, 0);
                wr_reg(i, 2, 32'(p));
                wr_reg(i, 1, 32'(d));
                wr_reg(i, 0, 0);
                wr_reg(i, 3, ctl);
                idle(2);
                meas(i, act, 4 * int'(p), hits);
                chk(hits == exp, "R6 R7 R5 active clocks per window", 32'(hits), 32'(exp));
                wr_reg(i, 3, 0);
            end
        end

        // R3: layout A with only one of its two enable bits
        wr_reg(0, 2, 4); wr_reg(0, 1, 2); wr_reg(0, 0, 0);
        wr_reg(0, 3, 32'h1);
        meas(0, 1'b1, 16, hits);
        chk(hits == 0, "R3 bit0 alone keeps pin idle", 32'(hits), 0);
        rd_reg(0, 0, v); chk(v == 0, "R3 bit0 alone keeps counter", v, 0);
        wr_reg(0, 3, 32'h8);
        meas(0, 1'b1, 16, hits);
        chk(hits == 0, "R3 bit3 alone keeps pin idle", 32'(hits), 0);

        // R5: layout A tick rate, one count per two clocks
        wr_reg(0, 2, 1000); wr_reg(0, 1, 0); wr_reg(0, 0, 0);
        wr_reg(0, 3, 32'h9);
        idle(3);
        rd_reg(0, 0, c1); idle(9); rd_reg(0, 0, c2);
        chk(c2 == c1 + 5, "R5 layout A advances every 2 clocks", c2, c1 + 5);
        wr_reg(0, 3, 0);

        // R5 R10: layout B tick rate, one count per clock
        wr_reg(1, 2, 1000); wr_reg(1, 1, 0); wr_reg(1, 0, 0);
        wr_reg(1, 3, 32'h9);
        idle(3);
        rd_reg(1, 0, c1); idle(4); rd_reg(1, 0, c2);
        chk(c2 == c1 + 5, "R5 R10 layout B advances every clock", c2, c1 + 5);

        // R9: nonzero counter write ignored, zero write restarts
        rd_reg(1, 0, c1); wr_reg(1, 0, 32'd500); rd_reg(1, 0, c2);
        chk(c2 == c1 + 3, "R9 nonzero counter write ignored", c2, c1 + 3);
        idle(20);
        wr_reg(1, 0, 0); rd_reg(1, 0, v);
        chk(v == 1, "R9 zero write restarts counter", v, 1);

        // R8: stop holds the counter and drives idle low
        wr_reg(1, 3, 0);
        rd_reg(1, 0, c1); idle(6); rd_reg(1, 0, c2);
        chk(c2 == c1, "R8 counter holds while stopped", c2, c1);
        chk(pout[1] == 1'b0, "R8 stopped pin at idle low", 32'(pout[1]), 0);

        // R4 R8: idle level high selected by bit 4 while stopped
        wr_reg(1, 3, 32'h10); idle(2);
        chk(pout[1] == 1'b1, "R4 R8 stopped pin at idle high", 32'(pout[1]), 1);

        // R4: reserved bits 1,5,8 and upper bits have no effect in layout C
        wr_reg(2, 3, 0); wr_reg(2, 2, 5); wr_reg(2, 1, 2); wr_reg(2, 0, 0);
        wr_reg(2, 3, 32'hA5A5_012B);
        rd_reg(2, 3, v); chk(v == 32'hA5A5_012B, "R4 control readback", v, 32'hA5A5_012B);
        idle(2);
        meas(2, 1'b1, 20, hits);
        chk(hits == 8, "R4 reserved bits no effect", 32'(hits), 8);

        // R5 R7: period zero keeps count at 0 and duty 1 holds active
        wr_reg(1, 3, 0); wr_reg(1, 2, 0); wr_reg(1, 1, 1); wr_reg(1, 0, 0);
        wr_reg(1, 3, 32'h9);
        idle(10);
        rd_reg(1, 0, v); chk(v == 0, "R5 period zero count stays 0", v, 0);
        chk(pout[1] == 1'b1, "R7 period zero pin active", 32'(pout[1]), 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule